// File: doc/BRIEF.md
# DMA register and interrupt unit

This block is the register slave of a multi-channel DMA controller. A host reaches it through a simple 32-bit request port inside a 4 KiB offset window. It holds five 32-bit words for every channel: source address, destination address, linked-list pointer, control and configuration. It also holds a global configuration word and a sync word, a read-only identification area, and the interrupt state of the controller. The default build has 8 channels. Setting `NUM_CH` to 2 gives the small variant.

The channel engines report events through one-cycle pulses on `tc_set` and `err_set`. Each pulse raises a sticky raw flag for its channel. A channel's configuration word carries that channel's terminal-count mask bit and error mask bit. Raw and masked views of both flag sets can be read back. The single `irq` output is high whenever any masked flag is set. Software clears raw flags by writing a one to each bit it wants cleared.

A read returns its data one cycle after the request. Writes take effect at the clock edge that samples them. Any access that does not decode to a defined register reads as zero, changes nothing, and raises `bus_err` with the response.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every channel word, the global configuration word, the sync word and both raw flag sets are zero. `irq`, `rd_valid` and `bus_err` are low.
- R2: Channel i has its words at offset 0x100 + 32·i. Source address is at +0x00, destination at +0x04, link pointer at +0x08, control at +0x0C and configuration at +0x10. A write stores all 32 bits. A read returns the stored word with `rd_valid` high in the cycle after the request.
- R3: A channel access is rejected in two cases: the channel index (offset bits [7:5]) is at or above `NUM_CH`, or the word inside the 32-byte window is +0x14 or higher. A rejected access reads 0, leaves all state unchanged and pulses `bus_err` with the response.
- R4: Global word 7 (offset 0x01C) reads a bitmap of enabled channels. Bit i of that bitmap equals bit 0 of channel i's configuration word.
- R5: A one-cycle pulse on `tc_set[i]` or `err_set[i]` sets raw bit i. The bit stays set until software clears it. Raw terminal-count flags read at word 5 (0x014) and raw error flags at word 6 (0x018).
- R6: Word 1 (0x004) reads the raw terminal-count flags ANDed with bit 15 of each channel's configuration word. Word 3 (0x00C) reads the raw error flags ANDed with bit 14. Word 0 (0x000) reads the OR of those two masked sets.
- R7: Writing word 2 (0x008) clears each raw terminal-count bit whose write-data bit is 1. Writing word 4 (0x010) does the same for raw error bits. Bits written as 0 are unchanged.
- R8: If a set pulse and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when some masked terminal-count bit or masked error bit is set. It follows the flag and configuration registers with no extra register stage.
- R10: Word 12 (0x030) is the global configuration word and word 13 (0x034) is the sync word. Both read back all 32 bits written to them.
- R11: Words 8 to 11 (0x020 to 0x02C) read 0 and raise no error.
- R12: Offsets 0xFE0 to 0xFFC read one identification byte per word in bits [7:0]. The bytes in order are 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. With `NUM_CH` = 2 the first byte is 0x81.
- R13: The following accesses are undefined:
  - any offset from 0x200 to 0xFDF;
  - reads of words 2, 4 and 14 to 63;
  - writes to global words other than 2, 4, 12 and 13;
  - writes to the identification area.

  An undefined access reads 0, changes no state and pulses `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the 4 KiB window; bits [1:0] are ignored |
| req_wdata | input | 32 | Write data |
| tc_set | input | NUM_CH | Terminal-count event pulses, one per channel |
| err_set | input | NUM_CH | Error event pulses, one per channel |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 32 | Read response data, zero when no read response is present |
| bus_err | output | 1 | Undefined or rejected access, aligned with the response |
| irq | output | 1 | Combined masked interrupt |

## Verification
`rd_valid`, `rd_data` and `bus_err` are registered. They are due exactly one clock after the edge that samples the request. Register writes and set pulses are visible to a read issued in the next cycle. `irq` follows flag and configuration changes at the same edge that updates those registers, because it has no register of its own. Stimulus is driven at falling edges. The reference model in the bench advances at each rising edge. All four outputs are compared with the model at every falling edge, so each result is checked half a cycle after it is due. The directed reads compare against constants at that same point.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int WORD_W   = 32;
    localparam int OFS_W    = 12;
    localparam int CH_IDX_W = 3;

    // word select inside one channel window
    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_LINK = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_CFG  = 3'd4;

    // configuration word bit positions
    localparam int CFG_EN_BIT       = 0;
    localparam int CFG_ERR_MASK_BIT = 14;
    localparam int CFG_TC_MASK_BIT  = 15;

    // global word indices
    localparam logic [5:0] GW_ANY_MASKED = 6'd0;
    localparam logic [5:0] GW_TC_MASKED  = 6'd1;
    localparam logic [5:0] GW_TC_CLEAR   = 6'd2;
    localparam logic [5:0] GW_ERR_MASKED = 6'd3;
    localparam logic [5:0] GW_ERR_CLEAR  = 6'd4;
    localparam logic [5:0] GW_TC_RAW     = 6'd5;
    localparam logic [5:0] GW_ERR_RAW    = 6'd6;
    localparam logic [5:0] GW_ENABLED    = 6'd7;
    localparam logic [5:0] GW_SOFT_FIRST = 6'd8;
    localparam logic [5:0] GW_SOFT_LAST  = 6'd11;
    localparam logic [5:0] GW_CTL_CFG    = 6'd12;
    localparam logic [5:0] GW_SYNC       = 6'd13;

    typedef enum logic [1:0] {
        AK_NONE,
        AK_CHAN,
        AK_GLOBAL,
        AK_IDENT
    } access_kind_e;

    typedef struct packed {
        access_kind_e          kind;
        logic [CH_IDX_W-1:0]   ch;
        logic [2:0]            sel;
        logic [5:0]            gword;
        logic [2:0]            id_idx;
        logic                  bad;
    } acc_dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] cfg;
    } chan_regs_t;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx, input logic eight_ch);
        logic [7:0] b;
        case (idx)
            3'd0:    b = eight_ch ? 8'h80 : 8'h81;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h0A;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic             valid,
    input  logic             write,
    input  logic [OFS_W-1:0] addr,
    output acc_dec_t         dec
);

    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];

    logic gw_readable;
    logic gw_writable;

    always_comb begin
        gw_writable = (addr[7:2] == GW_TC_CLEAR)  || (addr[7:2] == GW_ERR_CLEAR) ||
                      (addr[7:2] == GW_CTL_CFG)   || (addr[7:2] == GW_SYNC);
        gw_readable = (addr[7:2] <= GW_SYNC) &&
                      (addr[7:2] != GW_TC_CLEAR) && (addr[7:2] != GW_ERR_CLEAR);
    end

    always_comb begin
        dec        = '0;
        dec.kind   = AK_NONE;
        dec.ch     = addr[7:5];
        dec.sel    = addr[4:2];
        dec.gword  = addr[7:2];
        dec.id_idx = addr[4:2];
        if (valid) begin
            if (addr[11:8] == 4'h1) begin
                dec.kind = AK_CHAN;
                dec.bad  = (int'(addr[7:5]) >= NUM_CH) || (addr[4:2] > SEL_CFG);
            end else if (addr[11:5] == 7'h7F) begin
                dec.kind = AK_IDENT;
                dec.bad  = write;
            end else if (addr[11:8] == 4'h0) begin
                dec.kind = AK_GLOBAL;
                dec.bad  = write ? !gw_writable : !gw_readable;
            end else begin
                dec.bad  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [CH_IDX_W-1:0]       ch,
    input  logic [2:0]                sel,
    input  logic [WORD_W-1:0]         wdata,
    output chan_regs_t [NUM_CH-1:0]   regs_o,
    output logic [NUM_CH-1:0]         tc_mask_o,
    output logic [NUM_CH-1:0]         err_mask_o,
    output logic [NUM_CH-1:0]         en_o
);

    chan_regs_t [NUM_CH-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch == CH_IDX_W'(i)) begin
                    case (sel)
                        SEL_SRC:  bank_d[i].src  = wdata;
                        SEL_DST:  bank_d[i].dst  = wdata;
                        SEL_LINK: bank_d[i].link = wdata;
                        SEL_CTRL: bank_d[i].ctrl = wdata;
                        SEL_CFG:  bank_d[i].cfg  = wdata;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign regs_o = bank_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg_bits
        assign tc_mask_o[g]  = bank_q[g].cfg[CFG_TC_MASK_BIT];
        assign err_mask_o[g] = bank_q[g].cfg[CFG_ERR_MASK_BIT];
        assign en_o[g]       = bank_q[g].cfg[CFG_EN_BIT];
    end

    // R4
    cfg_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_CFG) |=>
        (((en_o & (NUM_CH'(1) << $past(ch))) != '0) == $past(wdata[CFG_EN_BIT])));

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    input  logic              tc_clr_we,
    input  logic              err_clr_we,
    input  logic [NUM_CH-1:0] clr_data,
    input  logic [NUM_CH-1:0] tc_mask,
    input  logic [NUM_CH-1:0] err_mask,
    output logic [NUM_CH-1:0] tc_raw,
    output logic [NUM_CH-1:0] err_raw,
    output logic [NUM_CH-1:0] tc_masked,
    output logic [NUM_CH-1:0] err_masked,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] err;
    } flags_t;

    flags_t fl_d, fl_q;
    logic [NUM_CH-1:0] tc_clr_bits;
    logic [NUM_CH-1:0] err_clr_bits;

    always_comb begin
        tc_clr_bits  = tc_clr_we  ? clr_data : '0;
        err_clr_bits = err_clr_we ? clr_data : '0;
        fl_d         = fl_q;
        // set pulses are ORed in after the clear, so a set wins
        fl_d.tc      = (fl_q.tc  & ~tc_clr_bits)  | tc_set;
        fl_d.err     = (fl_q.err & ~err_clr_bits) | err_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign tc_raw     = fl_q.tc;
    assign err_raw    = fl_q.err;
    assign tc_masked  = fl_q.tc  & tc_mask;
    assign err_masked = fl_q.err & err_mask;
    assign irq        = |{tc_masked, err_masked};

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set != '0) |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_clr_we |=> ((tc_raw & $past(clr_data & ~tc_set)) == '0));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_we |=> ((err_raw & $past(err_raw)) == $past(err_raw)));

    // R9
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((tc_raw | err_raw) != '0));

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              bus_err,
    output logic              irq
);

    localparam logic EIGHT_CH = (NUM_CH == 8);

    typedef struct packed {
        logic [WORD_W-1:0] ctl_cfg;
        logic [WORD_W-1:0] sync;
        logic              rsp_valid;
        logic              rsp_err;
        logic [WORD_W-1:0] rsp_data;
    } top_state_t;

    top_state_t st_d, st_q;
    acc_dec_t   dec;

    chan_regs_t [NUM_CH-1:0] ch_regs;
    logic [NUM_CH-1:0] tc_mask, err_mask, ch_en;
    logic [NUM_CH-1:0] tc_raw, err_raw, tc_masked, err_masked;
    logic              chan_we, glob_we, tc_clr_we, err_clr_we;
    logic [WORD_W-1:0] rd_mux;
    chan_regs_t        sel_regs;

    dma_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .dec   (dec)
    );

    always_comb begin
        chan_we    = req_valid && req_write && !dec.bad && (dec.kind == AK_CHAN);
        glob_we    = req_valid && req_write && !dec.bad && (dec.kind == AK_GLOBAL);
        tc_clr_we  = glob_we && (dec.gword == GW_TC_CLEAR);
        err_clr_we = glob_we && (dec.gword == GW_ERR_CLEAR);
    end

    dma_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (chan_we),
        .ch         (dec.ch),
        .sel        (dec.sel),
        .wdata      (req_wdata),
        .regs_o     (ch_regs),
        .tc_mask_o  (tc_mask),
        .err_mask_o (err_mask),
        .en_o       (ch_en)
    );

    dma_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr_we  (tc_clr_we),
        .err_clr_we (err_clr_we),
        .clr_data   (req_wdata[NUM_CH-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .tc_masked  (tc_masked),
        .err_masked (err_masked),
        .irq        (irq)
    );

    // channel word select
    always_comb begin
        sel_regs = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec.ch == CH_IDX_W'(i)) sel_regs = ch_regs[i];
        end
    end

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            AK_CHAN: begin
                case (dec.sel)
                    SEL_SRC:  rd_mux = sel_regs.src;
                    SEL_DST:  rd_mux = sel_regs.dst;
                    SEL_LINK: rd_mux = sel_regs.link;
                    SEL_CTRL: rd_mux = sel_regs.ctrl;
                    SEL_CFG:  rd_mux = sel_regs.cfg;
                    default:  rd_mux = '0;
                endcase
            end
            AK_GLOBAL: begin
                case (dec.gword)
                    GW_ANY_MASKED: rd_mux = WORD_W'(tc_masked | err_masked);
                    GW_TC_MASKED:  rd_mux = WORD_W'(tc_masked);
                    GW_ERR_MASKED: rd_mux = WORD_W'(err_masked);
                    GW_TC_RAW:     rd_mux = WORD_W'(tc_raw);
                    GW_ERR_RAW:    rd_mux = WORD_W'(err_raw);
                    GW_ENABLED:    rd_mux = WORD_W'(ch_en);
                    GW_CTL_CFG:    rd_mux = st_q.ctl_cfg;
                    GW_SYNC:       rd_mux = st_q.sync;
                    default:       rd_mux = '0;
                endcase
            end
            AK_IDENT: rd_mux = WORD_W'(ident_byte(dec.id_idx, EIGHT_CH));
            default:  rd_mux = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.rsp_err   = req_valid && dec.bad;
        st_d.rsp_data  = (req_valid && !req_write && !dec.bad) ? rd_mux : '0;
        if (glob_we && dec.gword == GW_CTL_CFG) st_d.ctl_cfg = req_wdata;
        if (glob_we && dec.gword == GW_SYNC)    st_d.sync    = req_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rsp_valid;
    assign rd_data  = st_q.rsp_data;
    assign bus_err  = st_q.rsp_err;

    // R13
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (rd_data == '0));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rd_valid && !bus_err));

    // R12
    id_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[11:2] == 10'h3F8) |=>
        (rd_data == (EIGHT_CH ? 32'h80 : 32'h81)));

endmodule

// File: tb/dma_regfile_tb.sv
`timescale 1ns/1ps
module dma_regfile_tb;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [NCH-1:0] tc_set = '0;
    logic [NCH-1:0] err_set = '0;
    logic        rd_valid, bus_err, irq;
    logic [31:0] rd_data;
    logic        rd_valid2, bus_err2, irq2;
    logic [31:0] rd_data2;

    always #2 clk = ~clk;

    dma_regfile #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .tc_set(tc_set), .err_set(err_set),
        .rd_valid(rd_valid), .rd_data(rd_data), .bus_err(bus_err), .irq(irq)
    );

    dma_regfile #(.NUM_CH(2)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .tc_set(tc_set[1:0]), .err_set(err_set[1:0]),
        .rd_valid(rd_valid2), .rd_data(rd_data2), .bus_err(bus_err2), .irq(irq2)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    bit    started = 0;
    string cur_tag = "R1";

    // ---------------- reference model ----------------
    logic [31:0] m_src [NCH];
    logic [31:0] m_dst [NCH];
    logic [31:0] m_lnk [NCH];
    logic [31:0] m_ctl [NCH];
    logic [31:0] m_cfg [NCH];
    logic [31:0] m_gcfg, m_sync, m_data;
    logic [NCH-1:0] m_tc, m_er, clr_tc, clr_er;
    logic        m_valid, m_err;
    int          a, ch, off, w;

    function automatic logic [7:0] id_byte(int k, int nch);
        logic [7:0] tbl [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (k == 0 && nch == 2) return 8'h81;
        return tbl[k];
    endfunction

    function automatic logic [NCH-1:0] mask_of(int bitpos);
        logic [NCH-1:0] m = '0;
        for (int i = 0; i < NCH; i++) m[i] = m_cfg[i][bitpos];
        return m;
    endfunction

    function automatic logic model_irq();
        return ((m_tc & mask_of(15)) | (m_er & mask_of(14))) != '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_src[i] = '0; m_dst[i] = '0; m_lnk[i] = '0; m_ctl[i] = '0; m_cfg[i] = '0;
            end
            m_gcfg = '0; m_sync = '0; m_tc = '0; m_er = '0;
            m_valid = 0; m_err = 0; m_data = '0;
        end else begin
            m_valid = 0; m_err = 0; m_data = '0; clr_tc = '0; clr_er = '0;
            if (req_valid) begin
                a = int'(req_addr) & 'hFFC;
                if (a >= 'h100 && a < 'h200) begin
                    ch  = (a - 'h100) / 32;
                    off = (a - 'h100) % 32;
                    if (ch < NCH && off <= 'h10) begin
                        if (req_write) begin
                            case (off)
                                'h00: m_src[ch] = req_wdata;
                                'h04: m_dst[ch] = req_wdata;
                                'h08: m_lnk[ch] = req_wdata;
                                'h0C: m_ctl[ch] = req_wdata;
                                default: m_cfg[ch] = req_wdata;
                            endcase
                        end else begin
                            case (off)
                                'h00: m_data = m_src[ch];
                                'h04: m_data = m_dst[ch];
                                'h08: m_data = m_lnk[ch];
                                'h0C: m_data = m_ctl[ch];
                                default: m_data = m_cfg[ch];
                            endcase
                        end
                    end else m_err = 1;
                end else if (a >= 'hFE0) begin
                    if (req_write) m_err = 1;
                    else m_data = 32'(id_byte((a - 'hFE0) / 4, NCH));
                end else if (a < 'h100) begin
                    w = a / 4;
                    if (req_write) begin
                        if (w == 2)       clr_tc = req_wdata[NCH-1:0];
                        else if (w == 4)  clr_er = req_wdata[NCH-1:0];
                        else if (w == 12) m_gcfg = req_wdata;
                        else if (w == 13) m_sync = req_wdata;
                        else m_err = 1;
                    end else begin
                        case (w)
                            0:  m_data = 32'((m_tc & mask_of(15)) | (m_er & mask_of(14)));
                            1:  m_data = 32'(m_tc & mask_of(15));
                            3:  m_data = 32'(m_er & mask_of(14));
                            5:  m_data = 32'(m_tc);
                            6:  m_data = 32'(m_er);
                            7:  m_data = 32'(mask_of(0));
                            8, 9, 10, 11: m_data = '0;
                            12: m_data = m_gcfg;
                            13: m_data = m_sync;
                            default: m_err = 1;
                        endcase
                    end
                end else m_err = 1;
                m_valid = !req_write;
            end
            m_tc = (m_tc & ~clr_tc) | tc_set;
            m_er = (m_er & ~clr_er) | err_set;
        end
    end

    // every-cycle comparison against the model, half a cycle after each edge
    always @(negedge clk) begin
        if (started && !done) begin
            n_tests++;
            if (rd_valid !== m_valid || bus_err !== m_err || rd_data !== m_data || irq !== model_irq()) begin
                n_fail++;
                $display("FAIL %s model: got v=%b e=%b d=%h irq=%b exp v=%b e=%b d=%h irq=%b",
                         cur_tag, rd_valid, bus_err, rd_data, irq, m_valid, m_err, m_data, model_irq());
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] ad, input logic [31:0] d, input string tag);
        cur_tag = tag;
        req_valid = 1; req_write = 1; req_addr = ad; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_expect(input logic [11:0] ad, input logic [31:0] exp, input logic exp_err, input string tag);
        cur_tag = tag;
        req_valid = 1; req_write = 0; req_addr = ad;
        @(negedge clk);
        req_valid = 0;
        check(tag, rd_data, exp);
        check(tag, {31'd0, bus_err}, {31'd0, exp_err});
    endtask

    task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e, input string tag);
        cur_tag = tag;
        tc_set = t; err_set = e;
        @(negedge clk);
        tc_set = '0; err_set = '0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check("R1", {29'd0, irq, rd_valid, bus_err}, 32'd0);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        rd_expect(12'h100, 32'h0, 0, "R1");
        rd_expect(12'h014, 32'h0, 0, "R1");

        // R2: channel words
        wr(12'h100, 32'hDEAD_BEEF, "R2");
        wr(12'h1EC, 32'h1234_5678, "R2");
        wr(12'h168, 32'hA5A5_0F0F, "R2");
        wr(12'h124, 32'h0000_FFFF, "R2");
        rd_expect(12'h100, 32'hDEAD_BEEF, 0, "R2");
        rd_expect(12'h1EC, 32'h1234_5678, 0, "R2");
        rd_expect(12'h168, 32'hA5A5_0F0F, 0, "R2");
        rd_expect(12'h124, 32'h0000_FFFF, 0, "R2");

        // R3: bad sub-word, and index beyond the 2-channel variant
        wr(12'h114, 32'hFFFF_FFFF, "R3");
        rd_expect(12'h114, 32'h0, 1, "R3");
        rd_expect(12'h100, 32'hDEAD_BEEF, 0, "R3");
        cur_tag = "R3";
        req_valid = 1; req_write = 0; req_addr = 12'h140;
        @(negedge clk);
        req_valid = 0;
        check("R3", {31'd0, bus_err2}, 32'd1);
        check("R3", rd_data2, 32'd0);

        // R4: enabled bitmap
        wr(12'h130, 32'h0000_0001, "R4");
        wr(12'h1B0, 32'h0000_0001, "R4");
        rd_expect(12'h01C, 32'h0000_0022, 0, "R4");

        // R5: sticky raw flags
        pulse(8'h05, 8'h80, "R5");
        repeat (2) @(negedge clk);
        rd_expect(12'h014, 32'h05, 0, "R5");
        rd_expect(12'h018, 32'h80, 0, "R5");
        check("R9", {31'd0, irq}, 32'd0);

        // R6 / R9: masks from configuration bits 15 and 14
        wr(12'h110, 32'h0000_8000, "R6");
        check("R9", {31'd0, irq}, 32'd1);
        wr(12'h1F0, 32'h0000_4001, "R6");
        rd_expect(12'h004, 32'h01, 0, "R6");
        rd_expect(12'h00C, 32'h80, 0, "R6");
        rd_expect(12'h000, 32'h81, 0, "R6");

        // R7: clearing
        wr(12'h008, 32'h0000_0001, "R7");
        rd_expect(12'h014, 32'h04, 0, "R7");
        check("R9", {31'd0, irq}, 32'd1);
        wr(12'h010, 32'h0000_0080, "R7");
        check("R9", {31'd0, irq}, 32'd0);
        rd_expect(12'h018, 32'h00, 0, "R7");

        // R8: set and clear in the same cycle
        cur_tag = "R8";
        tc_set = 8'h04; req_valid = 1; req_write = 1; req_addr = 12'h008; req_wdata = 32'h04;
        @(negedge clk);
        tc_set = '0; req_valid = 0; req_write = 0;
        rd_expect(12'h014, 32'h04, 0, "R8");

        // R10: global configuration and sync
        wr(12'h030, 32'hCAFE_0001, "R10");
        wr(12'h034, 32'h0000_FF00, "R10");
        rd_expect(12'h030, 32'hCAFE_0001, 0, "R10");
        rd_expect(12'h034, 32'h0000_FF00, 0, "R10");

        // R11: soft request words
        for (int k = 8; k < 12; k++) rd_expect(12'(k * 4), 32'h0, 0, "R11");

        // R12: identification bytes
        for (int k = 0; k < 8; k++) rd_expect(12'hFE0 + 12'(k * 4), 32'(id_byte(k, 8)), 0, "R12");
        cur_tag = "R12";
        req_valid = 1; req_write = 0; req_addr = 12'hFE0;
        @(negedge clk);
        req_valid = 0;
        check("R12", rd_data2, 32'h81);

        // R13: undefined accesses
        rd_expect(12'h008, 32'h0, 1, "R13");
        rd_expect(12'h038, 32'h0, 1, "R13");
        rd_expect(12'h200, 32'h0, 1, "R13");
        rd_expect(12'h800, 32'h0, 1, "R13");
        wr(12'h000, 32'hFFFF_FFFF, "R13");
        wr(12'h020, 32'hFFFF_FFFF, "R13");
        wr(12'hFE0, 32'hFFFF_FFFF, "R13");
        wr(12'h400, 32'hFFFF_FFFF, "R13");
        rd_expect(12'h014, 32'h04, 0, "R13");
        rd_expect(12'hFE0, 32'h80, 0, "R13");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule